// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block fills a small bank of 16-bit bus-interface configuration registers from an external three-wire serial EEPROM when the system comes out of reset. After a bus reset it holds an active-low local reset for a fixed number of cycles. It then reads the EEPROM one word at a time, producing chip select, serial clock and data-in itself and sampling the EEPROM's data-out line. The first word read decides the outcome. If the device does not answer, or the word is blank (FFFFh), the registers keep their built-in defaults. Otherwise every register is loaded from the EEPROM word at the same index.

The register map puts the device identifier at index 0 and the vendor code at index 1. Indices 2 to 5 hold the sizes of four local address spaces, and indices 6 to 9 hold the base addresses of those spaces. The host-side target logic uses `load_retry` to answer every access with a retry until loading ends. After that, the host may rewrite the registers through a simple write port and read them back through a read port.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: While `rst_n` is sampled low, every register i returns to its default 16'hC000 + i, `load_done` is 0, `load_retry` is 1, `lreset_n` is 0 and `ee_cs` is 0. This holds even when reset arrives in the middle of a load.
- R2: After reset is released, `lreset_n` stays low for exactly LRST_CYCLES clock cycles and then goes high. No chip select is raised before `lreset_n` is high.
- R3: Each word read raises `ee_cs` and sends nine command bits MSB first: a start bit 1, the read opcode 10, and the 6-bit word address. `ee_di` changes only while `ee_sk` is low. The block samples `ee_do` on each rising `ee_sk`: first a dummy bit, then 16 data bits MSB first.
- R4: `ee_sk` is low whenever `ee_cs` is low. Between two word reads, `ee_cs` stays low for at least one serial clock period (2*CLK_DIV system clocks).
- R5: If the dummy bit of the first read samples as 1 (line pulled high, no device fitted), no further word is read and all registers keep their defaults.
- R6: If the first word reads as FFFFh, no further word is read and all registers keep their defaults.
- R7: With a valid first word, words 0 to NUM_REGS-1 are read in ascending address order. Register i receives the word at address i.
- R8: `load_retry` is the inverse of `load_done` in every cycle. `load_retry` is high from reset until loading ends or the defaults are kept, and `load_done` then stays high until the next reset.
- R9: A host write (`host_we`) while `load_done` is 0 has no effect. After `load_done`, a write to an index below NUM_REGS updates that register. A write to an index at or above NUM_REGS changes nothing, and reads of such indices return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low bus reset |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM, pulled high when absent |
| lreset_n | output | 1 | Active-low local reset |
| load_retry | output | 1 | High while host target accesses must be retried |
| load_done | output | 1 | High once loading has ended or defaults were kept |
| host_we | input | 1 | Host register write strobe |
| host_waddr | input | 4 | Host write register index |
| host_wdata | input | 16 | Host write data |
| host_raddr | input | 4 | Host read register index |
| host_rdata | output | 16 | Register contents at `host_raddr` |

## Verification
The loader is tried against three EEPROM behaviours: a device holding a word pattern that differs at every address and bit position, a device whose first word is blank, and a missing device that leaves data-out high. The first shows MSB-first assembly and address-to-register mapping. The other two show that the fallback triggers on the right condition and stops after a single read. A host write during loading, a reset in the middle of a load, and a table of post-load writes that includes out-of-range indices separate the retry gating from normal register updates. A bench EEPROM model checks the command bits, the address order and the chip-select gaps on every frame.

// File: rtl/ee_cfg_pkg.sv
// Package: shared constants, state types and the read-command builder for
// the serial EEPROM configuration loader.
// Assumes a 6-bit word-addressed EEPROM with 16-bit words.
package ee_cfg_pkg;
    localparam int EE_AW      = 6;
    localparam int WORD_W     = 16;
    localparam int CMD_W      = 3 + EE_AW;          // start + opcode + address
    localparam int DUMMY_SLOT = CMD_W;              // slot of the leading 0 bit
    localparam int LAST_SLOT  = DUMMY_SLOT + WORD_W; // slot of data LSB

    typedef enum logic [1:0] {SQ_LRST, SQ_ISSUE, SQ_WAIT, SQ_FIN} seq_st_t;
    typedef enum logic [1:0] {RD_IDLE, RD_SHIFT, RD_GAP} rd_st_t;

    // Builds the command: start bit, read opcode, word address, MSB first.
    function automatic logic [CMD_W-1:0] rd_cmd(input logic [EE_AW-1:0] addr);
        return {1'b1, 2'b10, addr};
    endfunction
endpackage

// File: rtl/ee_word_reader.sv
// Module: reads one 16-bit word from a three-wire serial EEPROM.
// A start pulse launches a frame. Each serial period lasts 2*CLK_DIV clocks:
// low for the first half, high for the second. DI changes at the start of
// the period, and DO is sampled on the clock that raises SK. After the frame,
// CS is held low for one full serial period before word_done pulses.
// Assumes start is only pulsed while the reader is idle.
module ee_word_reader
    import ee_cfg_pkg::*;
#(
    parameter int CLK_DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [EE_AW-1:0]     word_addr,
    output logic                 ee_cs,
    output logic                 ee_sk,
    output logic                 ee_di,
    input  logic                 ee_do,
    output logic                 word_done,
    output logic                 word_present,
    output logic [WORD_W-1:0]    word_data
);
    localparam int CNT_W  = (2 * CLK_DIV > 1) ? $clog2(2 * CLK_DIV) : 1;
    localparam int SLOT_W = $clog2(LAST_SLOT + 1);
    localparam logic [CNT_W-1:0] RISE_AT = CNT_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] END_AT  = CNT_W'(2 * CLK_DIV - 1);

    rd_st_t             st;
    logic [CNT_W-1:0]   cnt;
    logic [SLOT_W-1:0]  slot;
    logic [CMD_W-1:0]   cmd_sh;
    logic [CMD_W-1:0]   cmd_w;

    assign cmd_w = rd_cmd(word_addr);

    // Frame sequencer: clock generation, command shifting and data capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= RD_IDLE;
            cnt          <= '0;
            slot         <= '0;
            cmd_sh       <= '0;
            ee_cs        <= 1'b0;
            ee_sk        <= 1'b0;
            ee_di        <= 1'b0;
            word_done    <= 1'b0;
            word_present <= 1'b0;
            word_data    <= '0;
        end else begin
            word_done <= 1'b0;
            case (st)
                RD_IDLE: begin
                    if (start) begin
                        st     <= RD_SHIFT;
                        ee_cs  <= 1'b1;
                        cnt    <= '0;
                        slot   <= '0;
                        ee_di  <= cmd_w[CMD_W-1];
                        cmd_sh <= {cmd_w[CMD_W-2:0], 1'b0};
                    end
                end
                RD_SHIFT: begin
                    if (cnt == RISE_AT) begin
                        ee_sk <= 1'b1;
                        if (slot == SLOT_W'(DUMMY_SLOT)) begin
                            word_present <= ~ee_do;
                        end else if (slot > SLOT_W'(DUMMY_SLOT)) begin
                            word_data <= {word_data[WORD_W-2:0], ee_do};
                        end
                    end
                    if (cnt == END_AT) begin
                        cnt   <= '0;
                        ee_sk <= 1'b0;
                        if (slot == SLOT_W'(LAST_SLOT)) begin
                            ee_cs <= 1'b0;
                            ee_di <= 1'b0;
                            st    <= RD_GAP;
                        end else begin
                            slot   <= slot + 1'b1;
                            ee_di  <= cmd_sh[CMD_W-1];
                            cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                RD_GAP: begin
                    if (cnt == END_AT) begin
                        cnt       <= '0;
                        st        <= RD_IDLE;
                        word_done <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    // R4
    sk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ee_cs |-> !ee_sk);

    // R4
    cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_cs) |=> !ee_cs);

    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ee_sk && $past(ee_sk)) |-> $stable(ee_di));
endmodule

// File: rtl/cfg_regbank.sv
// Module: the configuration register bank with a loader write port, a host
// write port and a host read port.
// Register i resets to DFLT_BASE + i. The loader port takes priority.
// Indices at or above NUM_REGS are ignored on write and read back as 0.
module cfg_regbank #(
    parameter int          NUM_REGS  = 10,
    parameter int          AW        = 4,
    parameter logic [15:0] DFLT_BASE = 16'hC000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [15:0]   ld_data,
    input  logic          hs_we,
    input  logic [AW-1:0] hs_addr,
    input  logic [15:0]   hs_data,
    input  logic [AW-1:0] rd_addr,
    output logic [15:0]   rd_data
);
    logic [NUM_REGS-1:0][15:0] regs;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        logic [15:0] q;
        // One register: default on reset, loader write, then host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= DFLT_BASE + 16'(g);
            end else if (ld_we && ld_addr == AW'(g)) begin
                q <= ld_data;
            end else if (hs_we && hs_addr == AW'(g)) begin
                q <= hs_data;
            end
        end
        assign regs[g] = q;
    end

    // Read mux; out-of-range indices return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_addr == AW'(i)) rd_data = regs[i];
        end
    end

    // R9
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ld_we && hs_we));
endmodule

// File: rtl/eeprom_cfg_loader.sv
// Module: top of the configuration loader. It holds the local reset, then
// reads EEPROM words 0..NUM_REGS-1 in order. The first word decides between
// loading and keeping the defaults. The host write port is enabled only after
// loading ends, and retry is forced until then.
// Assumes NUM_REGS <= 64 and a pulled-up data-out line.
module eeprom_cfg_loader
    import ee_cfg_pkg::*;
#(
    parameter int          NUM_REGS    = 10,
    parameter int          CLK_DIV     = 4,
    parameter int          LRST_CYCLES = 16,
    parameter logic [15:0] DFLT_BASE   = 16'hC000
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_di,
    input  logic        ee_do,
    output logic        lreset_n,
    output logic        load_retry,
    output logic        load_done,
    input  logic        host_we,
    input  logic [3:0]  host_waddr,
    input  logic [15:0] host_wdata,
    input  logic [3:0]  host_raddr,
    output logic [15:0] host_rdata
);
    localparam int RA_W  = 4;
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int LC_W  = $clog2(LRST_CYCLES + 1);

    seq_st_t            st;
    logic [LC_W-1:0]    lcnt;
    logic [IDX_W-1:0]   idx;
    logic               start;
    logic               wd_done;
    logic               wd_present;
    logic [WORD_W-1:0]  wd_data;
    logic               first_ok;
    logic               ld_we;
    logic               hs_we;

    assign first_ok   = wd_present && (wd_data != 16'hFFFF);
    assign ld_we      = wd_done && (st == SQ_WAIT) && ((idx != '0) || first_ok);
    assign hs_we      = host_we && load_done;
    assign load_retry = ~load_done;

    // Power-up sequencer: local reset hold, word issue and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= SQ_LRST;
            lcnt      <= '0;
            idx       <= '0;
            start     <= 1'b0;
            lreset_n  <= 1'b0;
            load_done <= 1'b0;
        end else begin
            start <= 1'b0;
            case (st)
                SQ_LRST: begin
                    if (lcnt == LC_W'(LRST_CYCLES - 1)) begin
                        lreset_n <= 1'b1;
                        st       <= SQ_ISSUE;
                    end else begin
                        lcnt <= lcnt + 1'b1;
                    end
                end
                SQ_ISSUE: begin
                    start <= 1'b1;
                    st    <= SQ_WAIT;
                end
                SQ_WAIT: begin
                    if (wd_done) begin
                        if ((idx == '0 && !first_ok) || idx == IDX_W'(NUM_REGS - 1)) begin
                            st        <= SQ_FIN;
                            load_done <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= SQ_ISSUE;
                        end
                    end
                end
                default: st <= SQ_FIN;
            endcase
        end
    end

    ee_word_reader #(.CLK_DIV(CLK_DIV)) u_reader (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .word_addr    (EE_AW'(idx)),
        .ee_cs        (ee_cs),
        .ee_sk        (ee_sk),
        .ee_di        (ee_di),
        .ee_do        (ee_do),
        .word_done    (wd_done),
        .word_present (wd_present),
        .word_data    (wd_data)
    );

    cfg_regbank #(.NUM_REGS(NUM_REGS), .AW(RA_W), .DFLT_BASE(DFLT_BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_we   (ld_we),
        .ld_addr (RA_W'(idx)),
        .ld_data (wd_data),
        .hs_we   (hs_we),
        .hs_addr (host_waddr),
        .hs_data (host_wdata),
        .rd_addr (host_raddr),
        .rd_data (host_rdata)
    );

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_done |=> load_done);

    // R2
    lrst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lreset_n |-> (!ee_cs && !load_done));

    // R6
    blank_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_done && st == SQ_WAIT && idx == '0 && wd_data == 16'hFFFF) |=> load_done);
endmodule

// File: tb/test_eeprom_cfg_loader.sv
`timescale 1ns/100ps
module test_eeprom_cfg_loader;
    localparam int NUM  = 10;
    localparam int DIV  = 4;
    localparam int LRST = 16;
    localparam logic [15:0] DFLT = 16'hC000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ee_cs, ee_sk, ee_di, ee_do, lreset_n, load_retry, load_done;
    logic host_we = 1'b0;
    logic [3:0]  host_waddr = '0, host_raddr = '0;
    logic [15:0] host_wdata = '0, host_rdata;

    int errors = 0, checks = 0, cyc = 0;

    always #2.5 clk = ~clk;

    eeprom_cfg_loader #(.NUM_REGS(NUM), .CLK_DIV(DIV), .LRST_CYCLES(LRST), .DFLT_BASE(DFLT))
        i_eeprom_cfg_loader (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .ee_do(ee_do), .lreset_n(lreset_n), .load_retry(load_retry), .load_done(load_done),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata));

    // EEPROM model: 64 words; DO shifts on falling SK; pulled high when idle or absent.
    logic [15:0] mem [64];
    bit   model_on = 1'b1;
    logic [8:0] cmd_rx = '0;
    logic [5:0] addr_rx = '0;
    int fall_n = 0, frames = 0, proto_err = 0;
    logic do_q = 1'b1;
    assign ee_do = do_q;

    always @(posedge ee_cs) begin
        fall_n = 0;
        if (rst_n) frames++;
    end
    always @(negedge ee_cs) do_q = 1'b1;
    always @(posedge ee_sk) if (ee_cs) cmd_rx = {cmd_rx[7:0], ee_di};
    always @(negedge ee_sk) if (ee_cs) begin
        fall_n++;
        if (!model_on) do_q = 1'b1;
        else if (fall_n == 9) begin
            if (cmd_rx[8:6] != 3'b110 || cmd_rx[5:0] != 6'(frames - 1)) proto_err++;
            addr_rx = cmd_rx[5:0];
            do_q = 1'b0;
        end else if (fall_n >= 10 && fall_n <= 25) do_q = mem[addr_rx][25 - fall_n];
        else do_q = 1'b1;
    end

    // Port monitors sampled away from the active edge.
    int low_run = 0, gap_err = 0, sk_err = 0, rty_err = 0, early_cs = 0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (load_retry !== ~load_done) rty_err++;
            if (!ee_cs && ee_sk) sk_err++;
            if (!lreset_n && ee_cs) early_cs++;
            if (!ee_cs) low_run++;
            else begin
                if (low_run > 0 && frames > 1 && low_run < 2 * DIV) gap_err++;
                low_run = 0;
            end
        end else low_run = 0;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pat(input int i);
        return 16'h3C5A ^ (16'(i) * 16'h0247);
    endfunction

    task automatic rd(input int a, output logic [15:0] v);
        host_raddr = 4'(a);
        #1 v = host_rdata;
    endtask

    task automatic reset_all();
        rst_n = 1'b0; host_we = 1'b0;
        repeat (3) @(negedge clk);
        frames = 0; proto_err = 0; gap_err = 0; sk_err = 0; rty_err = 0; early_cs = 0;
    endtask

    task automatic check_defaults(input string req);
        logic [15:0] v;
        for (int i = 0; i < NUM; i++) begin
            rd(i, v);
            chk(req, v, DFLT + 16'(i));
        end
    endtask

    task automatic wait_done();
        for (int k = 0; k < 20000 && !load_done; k++) @(negedge clk);
        chk("R8 done reached", load_done, 1);
    endtask

    // Host write vectors: {waddr, wdata, raddr, expected read}.
    localparam logic [39:0] VEC [6] = '{
        {4'd3,  16'h1111, 4'd3,  16'h1111},
        {4'd9,  16'h2222, 4'd9,  16'h2222},
        {4'd12, 16'h3333, 4'd9,  16'h2222},
        {4'd15, 16'h4444, 4'd15, 16'h0000},
        {4'd0,  16'hABCD, 4'd0,  16'hABCD},
        {4'd4,  16'h6666, 4'd3,  16'h1111}
    };

    initial begin
        logic [15:0] v;
        int n;
        for (int i = 0; i < 64; i++) mem[i] = pat(i);

        // Valid EEPROM.
        reset_all();
        check_defaults("R1 reset value");
        chk("R1 lreset_n", lreset_n, 0);
        chk("R1 done", load_done, 0);
        chk("R1 retry", load_retry, 1);
        chk("R1 cs", ee_cs, 0);
        rst_n = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!lreset_n && n < 1000);
        chk("R2 local reset length", n, LRST);
        for (int k = 0; k < 20000 && frames < 5; k++) @(negedge clk);
        chk("R8 retry during load", load_retry, 1);
        host_we = 1'b1; host_waddr = 4'd0; host_wdata = 16'h0BAD;
        @(negedge clk); host_we = 1'b0;
        wait_done();
        for (int i = 0; i < NUM; i++) begin
            rd(i, v);
            chk("R7 loaded word", v, pat(i));
        end
        chk("R9 write during load ignored", v == 16'h0BAD ? 0 : 1, 1);
        chk("R7 frame count", frames, NUM);
        chk("R3 command bits", proto_err, 0);
        chk("R4 cs gap", gap_err, 0);
        chk("R4 sk idle", sk_err, 0);
        chk("R2 cs before local reset", early_cs, 0);

        // Host writes after loading.
        foreach (VEC[j]) begin
            @(negedge clk);
            host_we = 1'b1; host_waddr = VEC[j][39:36]; host_wdata = VEC[j][35:20];
            @(negedge clk); host_we = 1'b0;
            rd(VEC[j][19:16], v);
            chk("R9 host write", v, VEC[j][15:0]);
        end
        chk("R8 done held", load_done, 1);
        chk("R8 retry tracks done", rty_err, 0);

        // Blank first word.
        mem[0] = 16'hFFFF;
        reset_all();
        rst_n = 1'b1;
        wait_done();
        repeat (20) @(negedge clk);
        chk("R6 single read", frames, 1);
        check_defaults("R6 defaults kept");
        mem[0] = pat(0);

        // No device fitted.
        model_on = 1'b0;
        reset_all();
        rst_n = 1'b1;
        wait_done();
        repeat (20) @(negedge clk);
        chk("R5 single read", frames, 1);
        check_defaults("R5 defaults kept");
        model_on = 1'b1;

        // Reset in the middle of a load.
        reset_all();
        rst_n = 1'b1;
        for (int k = 0; k < 20000 && frames < 4; k++) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_defaults("R1 mid-load reset");
        chk("R1 mid-load done", load_done, 0);
        frames = 0;
        rst_n = 1'b1;
        wait_done();
        rd(2, v);
        chk("R7 reload after reset", v, pat(2));
        chk("R8 retry tracks done", rty_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule